// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A single control word selects one of two division laws. The linear law divides by an even factor, 2·(n+1). The exponential law divides by 2^(n+1). Each law reads its own field in the word, and a mode bit chooses between them. The output clock rests at the idle level that the polarity input gives. Two one-cycle strobes tell the shift engine when the clock leaves its idle level and when it returns to it.

The divider runs only while `run_i` is high. When `run_i` rises, the block captures the control word and clears its phase. The first clock edge then follows one full half-period later. Changes to the control word during a transfer are held off until the next transfer starts. When `run_i` falls, the clock returns to idle at once.

Top module: `spi_dual_div`

## Requirements
- R1: With the mode bit (bit 12 of `div_cfg_i`) at 1, the half-period is n2+1 module-clock cycles. n2 is `div_cfg_i[7:0]`.
- R2: With the mode bit at 0, the half-period is 2^n1 module-clock cycles. n1 is `div_cfg_i[11:8]`.
- R3: The mode bit alone decides which field is used. The unused field has no effect on the clock.
- R4: While `run_i` is low, `sclk_o` equals `cpol_i` and both strobes are 0. This holds in the cycle after `run_i` falls, even mid-period.
- R5: Let E0 be the first rising clock edge that samples `run_i` high. `sclk_o` first changes after edge E0+H, where H is the half-period. It then changes again every H edges.
- R6: The control word is captured only at E0. A change to it during a transfer does not alter that transfer's timing.
- R7: `lead_o` is high for exactly the one cycle in which `sclk_o` has just left the idle level. `trail_o` is high for exactly the one cycle in which `sclk_o` has just returned to it. The two are never high together.
- R8: Linear mode with n2=0 gives a serial clock at half the module clock rate, so `sclk_o` toggles on every edge.
- R9: During reset, `sclk_o` equals `cpol_i` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Transfer active; its rise restarts the phase |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_cfg_i | input | 13 | Control word: [7:0] linear field, [11:8] exponential field, [12] law select (1 = linear) |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Strobe on the edge that leaves the idle level |
| trail_o | output | 1 | Strobe on the edge that returns to the idle level |

## Verification
The bench sweeps every linear field value from 0 to 15, plus the maximum of 255. It also sweeps exponential values 0 to 10, with both polarities, and checks clock level and strobes against an arithmetic model on every cycle. That catches an off-by-one divisor, which would shift every edge, and a swapped law bit, which would give 4 in place of 8 for equal fields. Some transfers rewrite the control word partway through, which exposes a divider that reloads mid-transfer and so changes its period at once. Transfers stopped while the clock is away from idle catch a design that lets the clock stay high or fires a stray trailing strobe. The first-edge delay is checked against a full half-period, so a design that toggles on the start edge is seen at once.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
    typedef enum logic {
        LAW_EXP = 1'b0,
        LAW_LIN = 1'b1
    } div_law_e;
endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
    import spi_div_pkg::*;
#(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int HALF_W = 16,
    parameter int CFG_W  = LIN_W + EXP_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [CFG_W-1:0]  div_cfg_i,
    output logic              active_o,
    output logic [HALF_W-1:0] half_o
);
    localparam int LAW_BIT = LIN_W + EXP_W;

    typedef struct packed {
        logic              active;
        logic [HALF_W-1:0] half;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic [LIN_W-1:0]  lin_fld;
    logic [EXP_W-1:0]  exp_fld;
    div_law_e          law;
    logic [HALF_W-1:0] half_new;

    always_comb begin
        lin_fld = div_cfg_i[LIN_W-1:0];
        exp_fld = div_cfg_i[LIN_W +: EXP_W];
        law     = div_law_e'(div_cfg_i[LAW_BIT]);
        if (law == LAW_LIN) half_new = HALF_W'(lin_fld) + HALF_W'(1);
        else                half_new = HALF_W'(1) << exp_fld;

        st_d        = st_q;
        st_d.active = run_i;
        if (run_i && !st_q.active) st_d.half = half_new;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{active: 1'b0, half: HALF_W'(1)};
        else         st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign half_o   = st_q.half;

    // R6
    half_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && run_i) |=> $stable(st_q.half));
endmodule

// File: rtl/spi_div_timer.sv
module spi_div_timer #(
    parameter int HALF_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              active_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    going;

    always_comb begin
        going  = active_i && run_i;
        tick_o = going && (st_q.cnt == half_i - HALF_W'(1));
        st_d   = st_q;
        if (!going || tick_o) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + HALF_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: '0};
        else         st_q <= st_d;
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < half_i);
endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    output logic phase_o,
    output logic lead_o,
    output logic trail_o
);
    typedef struct packed {
        logic phase;
        logic lead;
        logic trail;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = '{phase: st_q.phase, lead: 1'b0, trail: 1'b0};
        if (!run_i) begin
            st_d.phase = 1'b0;
        end else if (tick_i) begin
            st_d.phase = !st_q.phase;
            st_d.lead  = !st_q.phase;
            st_d.trail = st_q.phase;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign phase_o = st_q.phase;
    assign lead_o  = st_q.lead;
    assign trail_o = st_q.trail;

    // R4
    idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!st_q.phase && !st_q.lead && !st_q.trail));
    // R7
    lead_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lead |-> $rose(st_q.phase));
    // R7
    trail_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.trail |-> $fell(st_q.phase));
    // R7
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({st_q.lead, st_q.trail}));
endmodule

// File: rtl/spi_dual_div.sv
module spi_dual_div #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CFG_W = LIN_W + EXP_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             cpol_i,
    input  logic [CFG_W-1:0] div_cfg_i,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o
);
    localparam int EXP_SPAN = 1 << EXP_W;
    localparam int HALF_W   = (LIN_W + 1 > EXP_SPAN) ? LIN_W + 1 : EXP_SPAN;

    logic              active;
    logic [HALF_W-1:0] half;
    logic              tick;
    logic              phase;

    spi_div_cfg #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .HALF_W(HALF_W),
        .CFG_W (CFG_W)
    ) i_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .div_cfg_i(div_cfg_i),
        .active_o (active),
        .half_o   (half)
    );

    spi_div_timer #(
        .HALF_W(HALF_W)
    ) i_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_i),
        .active_i(active),
        .half_i  (half),
        .tick_o  (tick)
    );

    spi_div_phase i_phase (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .tick_i (tick),
        .phase_o(phase),
        .lead_o (lead_o),
        .trail_o(trail_o)
    );

    assign sclk_o = phase ^ cpol_i;
endmodule

// File: tb/test_spi_dual_div.sv
module test_spi_dual_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cpol = 1'b0;
    logic [12:0] cfg = '0;
    logic        sclk, lead, trail;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = !clk;

    spi_dual_div i_spi_dual_div (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cpol_i(cpol),
        .div_cfg_i(cfg), .sclk_o(sclk), .lead_o(lead), .trail_o(trail)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int half_of(input logic [12:0] c);
        if (c[12]) return int'(c[7:0]) + 1;
        return 1 << c[11:8];
    endfunction

    // Each cycle j counts rising edges after E0 (j=0 is E0 itself).
    task automatic xfer(input string req, input logic [12:0] c, input logic pol,
                        input int len, input int alt_at, input logic [12:0] alt);
        int h;
        h = half_of(c);
        @(negedge clk);
        cfg = c; cpol = pol; run = 1'b1;
        for (int j = 0; j < len; j++) begin
            int k;
            @(posedge clk); @(negedge clk);
            if (j == alt_at) cfg = alt;
            k = j / h;
            chk(req, "sclk", int'(sclk), int'(pol ^ k[0]));
            chk("R7", "lead", int'(lead), int'(j > 0 && j % h == 0 && k[0]));
            chk("R7", "trail", int'(trail), int'(j > 0 && j % h == 0 && !k[0]));
        end
        run = 1'b0;
        for (int j = 0; j < 2; j++) begin
            @(posedge clk); @(negedge clk);
            cfg = cfg ^ 13'h1fff;
            chk("R4", "idle sclk", int'(sclk), int'(pol));
            chk("R4", "idle strobes", int'({lead, trail}), 0);
        end
    endtask

    initial begin
        #3;
        // R9
        chk("R9", "reset sclk", int'(sclk), 0);
        chk("R9", "reset strobes", int'({lead, trail}), 0);
        cpol = 1'b1; #1;
        chk("R9", "reset sclk cpol1", int'(sclk), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: fastest setting
        xfer("R8", 13'h1000, 1'b0, 12, -1, '0);
        // R1 linear sweep, unused exponential field set to random-looking values
        for (int n = 0; n < 16; n++) begin
            xfer("R1", {1'b1, 4'(n * 7), 8'(n)}, 1'(n), 4 * (n + 1) + 1, -1, '0);
        end
        xfer("R1", {1'b1, 4'd0, 8'd255}, 1'b0, 3 * 256, -1, '0);
        // R2 exponential sweep, unused linear field nonzero
        for (int n = 0; n <= 10; n++) begin
            xfer("R2", {1'b0, 4'(n), 8'(8'h5a + n)}, 1'(n + 1), 3 * (1 << n) + 2, -1, '0);
        end
        // R3: identical fields, opposite law bit -> 4 versus 8
        xfer("R3", {1'b1, 4'd3, 8'd3}, 1'b0, 20, -1, '0);
        xfer("R3", {1'b0, 4'd3, 8'd3}, 1'b0, 20, -1, '0);
        // R5: first edge exactly one half-period after start
        xfer("R5", {1'b1, 4'd0, 8'd6}, 1'b1, 8, -1, '0);
        // R6: reprogram mid-transfer, timing must keep the captured value
        xfer("R6", {1'b1, 4'd0, 8'd4}, 1'b0, 30, 3, {1'b1, 4'd0, 8'd0});
        xfer("R6", {1'b0, 4'd2, 8'd0}, 1'b1, 30, 5, {1'b0, 4'd6, 8'd0});
        // R4: stop while clock is away from idle
        xfer("R4", {1'b1, 4'd0, 8'd2}, 1'b0, 5, -1, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule